// File: doc/BRIEF.md
# Dual-Port Control/Status Register Bank

This block is a bank of 64-bit control and status registers that two independent requesters can reach. One requester is a scan-style port whose address, shifted right by three, is the register index. The other is a memory-mapped port whose byte address, shifted right by three and offset by ten, gives the same index space. This lets the memory-mapped view start at the base address register instead of at index zero. Every access is a single-cycle request: valid, write, address, size in bytes and write data. A read answers one cycle later with a response pulse, the data and an error flag.

The bank holds a fault register, a control register and a set of plain registers. The fault register has replace, AND-in and OR-in write aliases. The control register has replace, set-bits and clear-bits write aliases. There is a primary base address register that only the scan port may write, and a secondary masked base register. An interrupt status register follows a status input and is read-only. Indices reserved for interrupt vector registers are not stored here: a write to them is forwarded on a one-cycle hook strobe. When the primary base register's stored content changes, the block emits a pulse together with the new value, so that an address decoder elsewhere can remap the window. Data words are big-endian, with bit 63 the most significant, and only aligned 8-byte accesses are legal.

Top module: `csr_dual_bank`

## Requirements
- R1: After reset every register reads zero, except the primary base register at index 0x0A. That register holds the configured default ANDed with the address mask, with the enable bit (bit 0) set. All response, error, hook and mapping-change outputs are low.
- R2: The scan index is address>>3 and the memory-mapped index is (address>>3)+0x0A. An access is legal only when size equals 8 and the address bits [2:0] are zero. An illegal access changes nothing, raises the port's error flag one cycle later, and an illegal read returns all ones.
- R3: At index 0x00 a write replaces the fault register. At index 0x01 a write ANDs the data into it, and at index 0x02 a write ORs the data into it. Reading 0x01 or 0x02 returns all ones.
- R4: At index 0x0E a write replaces the control register. At 0x12 a write sets the written bits, and at 0x13 it clears the written bits.
- R5: A scan write to index 0x0A stores the data ANDed with the address mask 0x0003_FFFF_FFF0_0000 plus bit 0. A memory-mapped write there leaves the register unchanged and raises that port's error flag.
- R6: A write to index 0x0B stores the data ANDed with 0x0003_FFFF_0000_0000.
- R7: Indices 0x06, 0x07, 0x0F and 0x14 are plain 64-bit read/write registers.
- R8: Index 0x15 returns the status input as sampled one clock earlier. A write there changes nothing and raises the port's error flag.
- R9: A read of any other index returns all ones. A legal write to any other index changes no register and raises no error.
- R10: A read presents rvalid, the data and err exactly one cycle after the request. The data reflects register contents before any write made in the same cycle.
- R11: When both ports write in the same cycle, the scan write is applied first and the memory-mapped write is applied to its result.
- R12: map_chg pulses for one cycle, in the cycle where map_base first shows the new value, exactly when a write changes the stored primary base value. map_base always shows the stored value.
- R13: A legal write to index 0x10 or 0x16..0x1A raises hook_vld for one cycle, with hook_idx and hook_data. If both ports do so in one cycle, the scan port's write is the one forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_valid | input | 1 | Scan port request |
| scan_write | input | 1 | Scan port write (1) or read (0) |
| scan_addr | input | AW | Scan port address, index = address>>3 |
| scan_size | input | 4 | Scan access size in bytes, legal value 8 |
| scan_wdata | input | 64 | Scan write data |
| scan_rvalid | output | 1 | Scan read response |
| scan_rdata | output | 64 | Scan read data |
| scan_err | output | 1 | Scan access error |
| mm_valid | input | 1 | Memory-mapped port request |
| mm_write | input | 1 | Memory-mapped write (1) or read (0) |
| mm_addr | input | AW | Memory-mapped byte address |
| mm_size | input | 4 | Memory-mapped access size in bytes, legal value 8 |
| mm_wdata | input | 64 | Memory-mapped write data |
| mm_rvalid | output | 1 | Memory-mapped read response |
| mm_rdata | output | 64 | Memory-mapped read data |
| mm_err | output | 1 | Memory-mapped access error |
| irq_status | input | 64 | Interrupt status source for index 0x15 |
| map_chg | output | 1 | Primary base content changed |
| map_base | output | 64 | Current primary base register value |
| hook_vld | output | 1 | Interrupt vector write strobe |
| hook_idx | output | 8 | Index of the forwarded write |
| hook_data | output | 64 | Data of the forwarded write |

## Verification
The assertions take every request to be a single cycle: each cycle with valid high is one access, and the cycle after it carries that access's response. They also take all inputs to be at known levels once reset is released. The memory-mapped blocking property further relies on the scan port not writing the base register in the same cycle. The bench drives each request for exactly one clock from a falling edge and then returns to idle, so every response lines up with one access. It holds the status input steady for at least a clock before reading index 0x15, and it exercises the same-cycle cases only in dedicated steps.

// File: rtl/csr_dual_bank_pkg.sv
package csr_dual_bank_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned IDX_W  = 8;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam idx_t IX_FAULT     = 8'h00;
    localparam idx_t IX_FAULT_AND = 8'h01;
    localparam idx_t IX_FAULT_OR  = 8'h02;
    localparam idx_t IX_ACT0      = 8'h06;
    localparam idx_t IX_ACT1      = 8'h07;
    localparam idx_t IX_BASE      = 8'h0A;
    localparam idx_t IX_BASE2     = 8'h0B;
    localparam idx_t IX_CTRL      = 8'h0E;
    localparam idx_t IX_ERRMASK   = 8'h0F;
    localparam idx_t IX_HOOK_A    = 8'h10;
    localparam idx_t IX_CTRL_SET  = 8'h12;
    localparam idx_t IX_CTRL_CLR  = 8'h13;
    localparam idx_t IX_DMAHI     = 8'h14;
    localparam idx_t IX_STAT      = 8'h15;
    localparam idx_t IX_HOOK_LO   = 8'h16;
    localparam idx_t IX_HOOK_HI   = 8'h1A;

    localparam int unsigned MM_IDX_OFS = 10;
    localparam logic [3:0]  LEGAL_SIZE = 4'd8;

    typedef struct packed {
        word_t fault;
        word_t act0;
        word_t act1;
        word_t base;
        word_t base2;
        word_t ctrl;
        word_t errmask;
        word_t dmahi;
        word_t stat;
    } bank_t;

    typedef struct packed {
        logic  rvalid;
        logic  err;
        word_t rdata;
    } resp_t;

    typedef struct packed {
        logic  vld;
        idx_t  idx;
        word_t data;
    } hook_t;

    function automatic logic is_hook(idx_t ix);
        return (ix == IX_HOOK_A) || ((ix >= IX_HOOK_LO) && (ix <= IX_HOOK_HI));
    endfunction

endpackage

// File: rtl/csr_port_decode.sv
module csr_port_decode
    import csr_dual_bank_pkg::*;
#(
    parameter int unsigned AW      = 16,
    parameter int unsigned IDX_OFS = 0
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    size,
    output logic          ok,
    output logic          bad,
    output logic          rd_req,
    output logic          wr_req,
    output idx_t          idx
);
    localparam int unsigned WW = AW + 1;

    logic [WW-1:0] wide;

    assign ok     = valid && (size == LEGAL_SIZE) && (addr[2:0] == 3'b000);
    assign bad    = valid && !ok;
    assign rd_req = valid && !write;
    assign wr_req = ok && write;

    // widen before the offset so a large byte address cannot wrap onto a register
    assign wide = WW'(addr >> 3) + WW'(IDX_OFS);
    assign idx  = (wide > WW'({IDX_W{1'b1}})) ? {IDX_W{1'b1}} : wide[IDX_W-1:0];

endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
    import csr_dual_bank_pkg::*;
(
    input  bank_t bank,
    input  idx_t  idx,
    input  logic  ok,
    output word_t data
);
    always_comb begin
        data = '1;
        if (ok) begin
            case (idx)
                IX_FAULT:   data = bank.fault;
                IX_ACT0:    data = bank.act0;
                IX_ACT1:    data = bank.act1;
                IX_BASE:    data = bank.base;
                IX_BASE2:   data = bank.base2;
                IX_CTRL:    data = bank.ctrl;
                IX_ERRMASK: data = bank.errmask;
                IX_DMAHI:   data = bank.dmahi;
                IX_STAT:    data = bank.stat;
                default:    data = '1;
            endcase
        end
    end
endmodule

// File: rtl/csr_dual_bank.sv
module csr_dual_bank
    import csr_dual_bank_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter logic [63:0] BAR_MASK  = 64'h0003_FFFF_FFF0_0000,
    parameter logic [63:0] BAR2_MASK = 64'h0003_FFFF_0000_0000,
    parameter logic [63:0] BAR_RESET = 64'h0000_0123_4560_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_valid,
    input  logic          scan_write,
    input  logic [AW-1:0] scan_addr,
    input  logic [3:0]    scan_size,
    input  logic [63:0]   scan_wdata,
    output logic          scan_rvalid,
    output logic [63:0]   scan_rdata,
    output logic          scan_err,
    input  logic          mm_valid,
    input  logic          mm_write,
    input  logic [AW-1:0] mm_addr,
    input  logic [3:0]    mm_size,
    input  logic [63:0]   mm_wdata,
    output logic          mm_rvalid,
    output logic [63:0]   mm_rdata,
    output logic          mm_err,
    input  logic [63:0]   irq_status,
    output logic          map_chg,
    output logic [63:0]   map_base,
    output logic          hook_vld,
    output logic [7:0]    hook_idx,
    output logic [63:0]   hook_data
);
    localparam int unsigned NPORT   = 2;
    localparam int unsigned P_SCAN  = 0;
    localparam int unsigned P_MM    = 1;
    localparam word_t       BASE_KEEP = BAR_MASK | 64'd1;
    localparam word_t       BASE_RST  = (BAR_RESET & BAR_MASK) | 64'd1;

    typedef struct packed {
        bank_t bank;
        resp_t rsp_scan;
        resp_t rsp_mm;
        hook_t hook;
        logic  map_chg;
    } state_t;

    state_t st_d, st_q;

    logic [NPORT-1:0] p_valid, p_write, p_ok, p_bad, p_rd, p_wr;
    logic [AW-1:0]    p_addr [NPORT];
    logic [3:0]       p_size [NPORT];
    idx_t             p_idx  [NPORT];
    word_t            p_rdat [NPORT];

    assign p_valid = {mm_valid, scan_valid};
    assign p_write = {mm_write, scan_write};
    assign p_addr[P_SCAN] = scan_addr;
    assign p_addr[P_MM]   = mm_addr;
    assign p_size[P_SCAN] = scan_size;
    assign p_size[P_MM]   = mm_size;

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
        csr_port_decode #(
            .AW      (AW),
            .IDX_OFS ((gp == P_MM) ? MM_IDX_OFS : 0)
        ) u_dec (
            .valid  (p_valid[gp]),
            .write  (p_write[gp]),
            .addr   (p_addr[gp]),
            .size   (p_size[gp]),
            .ok     (p_ok[gp]),
            .bad    (p_bad[gp]),
            .rd_req (p_rd[gp]),
            .wr_req (p_wr[gp]),
            .idx    (p_idx[gp])
        );

        csr_read_mux u_rmux (
            .bank (st_q.bank),
            .idx  (p_idx[gp]),
            .ok   (p_ok[gp]),
            .data (p_rdat[gp])
        );
    end

    // one write alias applied to a bank image; the base register honours only the scan port
    function automatic bank_t wr_apply(bank_t b, idx_t ix, word_t d, logic from_scan);
        bank_t n;
        n = b;
        case (ix)
            IX_FAULT:     n.fault   = d;
            IX_FAULT_AND: n.fault   = b.fault & d;
            IX_FAULT_OR:  n.fault   = b.fault | d;
            IX_ACT0:      n.act0    = d;
            IX_ACT1:      n.act1    = d;
            IX_BASE:      if (from_scan) n.base = d & BASE_KEEP;
            IX_BASE2:     n.base2   = d & BAR2_MASK;
            IX_CTRL:      n.ctrl    = d;
            IX_CTRL_SET:  n.ctrl    = b.ctrl | d;
            IX_CTRL_CLR:  n.ctrl    = b.ctrl & ~d;
            IX_ERRMASK:   n.errmask = d;
            IX_DMAHI:     n.dmahi   = d;
            default:      ;
        endcase
        return n;
    endfunction

    function automatic logic wr_refused(idx_t ix, logic from_scan);
        return (ix == IX_STAT) || ((ix == IX_BASE) && !from_scan);
    endfunction

    always_comb begin
        bank_t b;
        st_d = st_q;

        b = st_q.bank;
        if (p_wr[P_SCAN]) b = wr_apply(b, p_idx[P_SCAN], scan_wdata, 1'b1);
        if (p_wr[P_MM])   b = wr_apply(b, p_idx[P_MM],   mm_wdata,   1'b0);
        b.stat    = irq_status;
        st_d.bank = b;

        st_d.rsp_scan.rvalid = p_rd[P_SCAN];
        st_d.rsp_scan.rdata  = p_rdat[P_SCAN];
        st_d.rsp_scan.err    = p_bad[P_SCAN]
                             | (p_wr[P_SCAN] & wr_refused(p_idx[P_SCAN], 1'b1));

        st_d.rsp_mm.rvalid = p_rd[P_MM];
        st_d.rsp_mm.rdata  = p_rdat[P_MM];
        st_d.rsp_mm.err    = p_bad[P_MM]
                           | (p_wr[P_MM] & wr_refused(p_idx[P_MM], 1'b0));

        st_d.map_chg = (b.base != st_q.bank.base);

        st_d.hook = '0;
        if (p_wr[P_SCAN] && is_hook(p_idx[P_SCAN])) begin
            st_d.hook.vld  = 1'b1;
            st_d.hook.idx  = p_idx[P_SCAN];
            st_d.hook.data = scan_wdata;
        end else if (p_wr[P_MM] && is_hook(p_idx[P_MM])) begin
            st_d.hook.vld  = 1'b1;
            st_d.hook.idx  = p_idx[P_MM];
            st_d.hook.data = mm_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.bank.base <= BASE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_rvalid = st_q.rsp_scan.rvalid;
    assign scan_rdata  = st_q.rsp_scan.rdata;
    assign scan_err    = st_q.rsp_scan.err;
    assign mm_rvalid   = st_q.rsp_mm.rvalid;
    assign mm_rdata    = st_q.rsp_mm.rdata;
    assign mm_err      = st_q.rsp_mm.err;
    assign map_chg     = st_q.map_chg;
    assign map_base    = st_q.bank.base;
    assign hook_vld    = st_q.hook.vld;
    assign hook_idx    = st_q.hook.idx;
    assign hook_data   = st_q.hook.data;

endmodule

// File: rtl/csr_dual_bank_chk.sv
module csr_dual_bank_chk #(
    parameter int unsigned AW       = 16,
    parameter logic [63:0] BAR_MASK = 64'h0003_FFFF_FFF0_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scan_valid,
    input logic          scan_write,
    input logic [AW-1:0] scan_addr,
    input logic [3:0]    scan_size,
    input logic [63:0]   scan_wdata,
    input logic          scan_rvalid,
    input logic [63:0]   scan_rdata,
    input logic          scan_err,
    input logic          mm_valid,
    input logic          mm_write,
    input logic [AW-1:0] mm_addr,
    input logic [3:0]    mm_size,
    input logic [63:0]   mm_wdata,
    input logic          mm_rvalid,
    input logic [63:0]   mm_rdata,
    input logic          mm_err,
    input logic [63:0]   irq_status,
    input logic          map_chg,
    input logic [63:0]   map_base,
    input logic          hook_vld,
    input logic [7:0]    hook_idx,
    input logic [63:0]   hook_data
);
    AST_SCAN_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_err |-> $past(scan_valid)); // R2

    AST_BAD_SIZE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && !scan_write && scan_size != 4'd8) |=> (scan_err && scan_rdata == '1)); // R2

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_valid && !mm_write) |=> mm_rvalid); // R10

    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        mm_rvalid |-> $past(mm_valid && !mm_write)); // R10

    AST_MM_BASE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_valid && mm_write && mm_size == 4'd8 && mm_addr == '0 && !(scan_valid && scan_write))
        |=> ($stable(map_base) && mm_err)); // R5

    AST_BASE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (map_base & ~(BAR_MASK | 64'd1)) == 64'd0); // R5

    AST_MAP_CHG_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        map_chg |-> (map_base != $past(map_base))); // R12

    AST_MAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !map_chg |-> $stable(map_base)); // R12

    AST_HOOK_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        hook_vld |-> (hook_idx == 8'h10 || (hook_idx >= 8'h16 && hook_idx <= 8'h1A))); // R13

endmodule

bind csr_dual_bank csr_dual_bank_chk #(.AW(AW), .BAR_MASK(BAR_MASK)) u_chk (.*);

// File: tb/csr_dual_bank_test.sv
module csr_dual_bank_test;
    localparam int unsigned AW        = 16;
    localparam logic [63:0] BAR_MASK  = 64'h0003_FFFF_FFF0_0000;
    localparam logic [63:0] BAR2_MASK = 64'h0003_FFFF_0000_0000;
    localparam logic [63:0] BAR_RESET = 64'h0000_0123_4560_0000;
    localparam logic [63:0] ONES      = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_valid = 0, scan_write = 0;
    logic [AW-1:0] scan_addr = '0;
    logic [3:0]    scan_size = '0;
    logic [63:0]   scan_wdata = '0;
    logic          scan_rvalid, scan_err;
    logic [63:0]   scan_rdata;
    logic          mm_valid = 0, mm_write = 0;
    logic [AW-1:0] mm_addr = '0;
    logic [3:0]    mm_size = '0;
    logic [63:0]   mm_wdata = '0;
    logic          mm_rvalid, mm_err;
    logic [63:0]   mm_rdata;
    logic [63:0]   irq_status = '0;
    logic          map_chg, hook_vld;
    logic [63:0]   map_base, hook_data;
    logic [7:0]    hook_idx;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic [63:0] r [64];

    always #4 clk = ~clk;

    csr_dual_bank #(.AW(AW), .BAR_MASK(BAR_MASK), .BAR2_MASK(BAR2_MASK), .BAR_RESET(BAR_RESET)) uut (
        .clk(clk), .rst_n(rst_n),
        .scan_valid(scan_valid), .scan_write(scan_write), .scan_addr(scan_addr),
        .scan_size(scan_size), .scan_wdata(scan_wdata),
        .scan_rvalid(scan_rvalid), .scan_rdata(scan_rdata), .scan_err(scan_err),
        .mm_valid(mm_valid), .mm_write(mm_write), .mm_addr(mm_addr),
        .mm_size(mm_size), .mm_wdata(mm_wdata),
        .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata), .mm_err(mm_err),
        .irq_status(irq_status), .map_chg(map_chg), .map_base(map_base),
        .hook_vld(hook_vld), .hook_idx(hook_idx), .hook_data(hook_data)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit implemented(int ix);
        return ix == 0 || ix == 6 || ix == 7 || ix == 10 || ix == 11 ||
               ix == 14 || ix == 15 || ix == 20 || ix == 21;
    endfunction

    function automatic bit hook_ix(int ix);
        return ix == 16 || (ix >= 22 && ix <= 26);
    endfunction

    function automatic string tag_of(int ix);
        if (ix <= 2) return "R3";
        if (ix == 10) return "R5";
        if (ix == 11) return "R6";
        if (ix == 14 || ix == 18 || ix == 19) return "R4";
        if (ix == 6 || ix == 7 || ix == 15 || ix == 20) return "R7";
        if (ix == 21) return "R8";
        if (hook_ix(ix)) return "R13";
        return "R9";
    endfunction

    function automatic logic [63:0] mdl_rd(int ix);
        if (ix < 64 && implemented(ix)) return (ix == 21) ? irq_status : r[ix];
        return ONES;
    endfunction

    task automatic mdl_wr(int ix, logic [63:0] d, bit from_scan, inout bit err);
        case (ix)
            0:  r[0] = d;
            1:  r[0] = r[0] & d;
            2:  r[0] = r[0] | d;
            6, 7, 15, 20: r[ix] = d;
            10: if (from_scan) r[10] = d & (BAR_MASK | 64'd1); else err = 1;
            11: r[11] = d & BAR2_MASK;
            14: r[14] = d;
            18: r[14] = r[14] | d;
            19: r[14] = r[14] & ~d;
            21: err = 1;
            default: ;
        endcase
    endtask

    task automatic access(string tag,
                          bit sv, bit sw, logic [AW-1:0] sa, logic [3:0] ss, logic [63:0] sd,
                          bit mv, bit mw, logic [AW-1:0] ma, logic [3:0] ms, logic [63:0] md);
        bit s_ok, m_ok, s_err, m_err, hv;
        int s_ix, m_ix, hi;
        logic [63:0] s_rd, m_rd, hd, old_base;
        s_ok = sv && ss == 4'd8 && sa[2:0] == 3'b000;
        m_ok = mv && ms == 4'd8 && ma[2:0] == 3'b000;
        s_ix = int'(sa >> 3);
        m_ix = int'(ma >> 3) + 10;
        s_rd = s_ok ? mdl_rd(s_ix) : ONES;
        m_rd = m_ok ? mdl_rd(m_ix) : ONES;
        s_err = sv && !s_ok;
        m_err = mv && !m_ok;
        old_base = r[10];
        hv = 0; hi = 0; hd = '0;
        if (s_ok && sw) begin
            mdl_wr(s_ix, sd, 1'b1, s_err);
            if (hook_ix(s_ix)) begin hv = 1; hi = s_ix; hd = sd; end
        end
        if (m_ok && mw) begin
            mdl_wr(m_ix, md, 1'b0, m_err);
            if (hook_ix(m_ix) && !hv) begin hv = 1; hi = m_ix; hd = md; end
        end
        @(negedge clk);
        scan_valid = sv; scan_write = sw; scan_addr = sa; scan_size = ss; scan_wdata = sd;
        mm_valid = mv; mm_write = mw; mm_addr = ma; mm_size = ms; mm_wdata = md;
        @(negedge clk);
        scan_valid = 0; mm_valid = 0;
        chk(tag, "scan_rvalid", 64'(scan_rvalid), 64'(sv && !sw));
        if (sv && !sw) chk(tag, "scan_rdata", scan_rdata, s_rd);
        chk(tag, "scan_err", 64'(scan_err), 64'(s_err));
        chk(tag, "mm_rvalid", 64'(mm_rvalid), 64'(mv && !mw));
        if (mv && !mw) chk(tag, "mm_rdata", mm_rdata, m_rd);
        chk(tag, "mm_err", 64'(mm_err), 64'(m_err));
        chk(tag, "map_chg", 64'(map_chg), 64'(r[10] != old_base));
        chk(tag, "map_base", map_base, r[10]);
        chk(tag, "hook_vld", 64'(hook_vld), 64'(hv));
        if (hv) begin
            chk(tag, "hook_idx", 64'(hook_idx), 64'(hi));
            chk(tag, "hook_data", hook_data, hd);
        end
    endtask

    task automatic srd(string tag, int ix);
        access(tag, 1, 0, AW'(ix * 8), 4'd8, '0, 0, 0, '0, '0, '0);
    endtask
    task automatic swr(string tag, int ix, logic [63:0] d);
        access(tag, 1, 1, AW'(ix * 8), 4'd8, d, 0, 0, '0, '0, '0);
    endtask
    task automatic mrd(string tag, int ix);
        access(tag, 0, 0, '0, '0, '0, 1, 0, AW'((ix - 10) * 8), 4'd8, '0);
    endtask
    task automatic mwr(string tag, int ix, logic [63:0] d);
        access(tag, 0, 0, '0, '0, '0, 1, 1, AW'((ix - 10) * 8), 4'd8, d);
    endtask

    function automatic logic [63:0] pat(int ix, int salt);
        return 64'hF0F0_3C3C_A5A5_0FF0 ^ {8'(ix + salt), 56'h0} ^ (64'd1 << ix)
               ^ (64'(salt) * 64'h0123_4567_89AB_CDEF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) r[i] = '0;
        r[10] = (BAR_RESET & BAR_MASK) | 64'd1;
        irq_status = 64'h0000_0013_0000_0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state at the ports
        chk("R1", "scan_rvalid", 64'(scan_rvalid), 64'd0);
        chk("R1", "mm_rvalid", 64'(mm_rvalid), 64'd0);
        chk("R1", "scan_err", 64'(scan_err), 64'd0);
        chk("R1", "mm_err", 64'(mm_err), 64'd0);
        chk("R1", "map_chg", 64'(map_chg), 64'd0);
        chk("R1", "hook_vld", 64'(hook_vld), 64'd0);
        chk("R1", "map_base", map_base, (BAR_RESET & BAR_MASK) | 64'd1);

        // R1 / R9 read sweep of the index space after reset
        for (int ix = 0; ix < 32; ix++) srd(implemented(ix) ? "R1" : "R9", ix);

        // scan write sweep, then read back everything
        for (int ix = 0; ix < 32; ix++) swr(tag_of(ix), ix, pat(ix, 1));
        for (int ix = 0; ix < 32; ix++) srd(tag_of(ix), ix);

        // R3 aliases against a known fault value
        swr("R3", 0, 64'hFF00_FF00_FF00_FF00);
        swr("R3", 1, 64'hF0F0_F0F0_F0F0_F0F0);
        srd("R3", 0);
        swr("R3", 2, 64'h0000_0000_0000_000F);
        srd("R3", 0);

        // R4 set/clear aliases
        swr("R4", 14, 64'h8000_0000_0000_0001);
        swr("R4", 18, 64'h0400_0000_0000_0010);
        srd("R4", 14);
        swr("R4", 19, 64'h8000_0000_0000_0010);
        srd("R4", 14);

        // memory-mapped sweep over byte addresses reaching indices 0x0A..0x21
        for (int ix = 10; ix < 34; ix++) mwr(tag_of(ix), ix, pat(ix, 2));
        for (int ix = 10; ix < 34; ix++) mrd(tag_of(ix), ix);

        // R2 illegal sizes and misaligned addresses on both ports
        for (int s = 0; s < 16; s++) begin
            if (s != 8) begin
                access("R2", 0, 0, '0, '0, '0, 1, 1, AW'(32), 4'(s), 64'hDEAD_BEEF_0000_0000);
                access("R2", 0, 0, '0, '0, '0, 1, 0, AW'(32), 4'(s), '0);
                access("R2", 1, 0, AW'(112), 4'(s), '0, 0, 0, '0, '0, '0);
            end
        end
        for (int a = 1; a < 8; a++) begin
            access("R2", 1, 1, AW'(112 + a), 4'd8, 64'h1234, 0, 0, '0, '0, '0);
            access("R2", 0, 0, '0, '0, '0, 1, 0, AW'(32 + a), 4'd8, '0);
        end
        srd("R2", 14);
        access("R2", 0, 0, '0, '0, '0, 1, 0, AW'(16'hFFF8), 4'd8, '0);

        // R8 status follows the input, writes refused
        for (int k = 0; k < 4; k++) begin
            irq_status = pat(k, 5);
            srd("R8", 21);
            mrd("R8", 21);
            swr("R8", 21, 64'h0);
            srd("R8", 21);
        end

        // R5 / R12 base register behaviour
        swr("R5", 10, 64'hFFFF_FFFF_FFFF_FFFF);
        swr("R12", 10, 64'hFFFF_FFFF_FFFF_FFFF);
        swr("R12", 10, 64'hFFFF_FFFF_FFFF_FFFE);
        swr("R12", 10, 64'h0000_0000_0010_0001);
        mwr("R5", 10, 64'h0000_0001_0000_0001);
        srd("R5", 10);

        // R6 secondary base
        swr("R6", 11, ONES);
        mrd("R6", 11);

        // R11 same-cycle writes from both ports
        swr("R11", 14, 64'h0F0F_0000_0000_0000);
        access("R11", 1, 1, AW'(18 * 8), 4'd8, 64'h00F0_0000_0000_00FF,
                      1, 1, AW'((19 - 10) * 8), 4'd8, 64'h0F00_0000_0000_000F);
        srd("R11", 14);
        access("R11", 1, 1, AW'(14 * 8), 4'd8, 64'h1111,
                      1, 1, AW'((14 - 10) * 8), 4'd8, 64'h2222);
        srd("R11", 14);
        access("R11", 1, 1, AW'(10 * 8), 4'd8, 64'h0000_0002_0030_0001,
                      1, 1, AW'(0), 4'd8, 64'h0000_0000_0000_0000);

        // R13 hook priority
        access("R13", 1, 1, AW'(16 * 8), 4'd8, 64'hAAAA,
                      1, 1, AW'((22 - 10) * 8), 4'd8, 64'hBBBB);
        mwr("R13", 26, 64'hCCCC);
        access("R13", 1, 1, AW'(16 * 8), 4'd6, 64'hAAAA, 0, 0, '0, '0, '0);

        // R10 read and write of the same register in one cycle
        access("R10", 1, 0, AW'(20 * 8), 4'd8, '0,
                      1, 1, AW'((20 - 10) * 8), 4'd8, 64'h5555_6666_7777_8888);
        srd("R10", 20);
        access("R10", 1, 1, AW'(15 * 8), 4'd8, 64'h9999,
                      1, 0, AW'((15 - 10) * 8), 4'd8, '0);
        mrd("R10", 15);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule